// File: doc/BRIEF.md
# Memory Profile Selector

This block decides which of four stored hearing profiles (A, B, C, D, encoded as index 0 to 3) is in force. It watches two memory-select pins that have already been synchronized, and reports the active index together with a one-cycle change pulse. The audio path uses that pulse to begin a fade. The pins may carry momentary push buttons or static switches. A four-way mode input sets how they are read:

- mode 0: MS1 push button only.
- mode 1: MS1 push button plus a static MS2 that forces D.
- mode 2: two static switches read as a code.
- mode 3: static MS1 plus a static MS2 that forces D.

The MS2 override is meant for a reed switch that closes near a telephone handset. While the override holds, the selector shows D. When the override ends, the selector returns to the profile it showed before. The return can be delayed by a debounce window measured in millisecond ticks.

Configuration inputs are:

- a four-bit valid mask, where bit i set means profile i is valid;
- the pull-resistor setting, which sets which level of MS2 counts as closed;
- the debounce length;
- a power-on hold flag, which suppresses button presses while the device settles.

Top module: `memsel_ctrl`

## Requirements
- R1: While reset is applied, and on the first cycle after it, the index output is 0 (A) and the change pulse is low.
- R2: In mode 0, each rising edge of MS1 (high means pressed) moves the index to the next higher index whose mask bit is set. When no higher index has its mask bit set, the index goes to 0 (A). Profile A is used whether or not mask bit 0 is set. The new index appears on the clock edge that samples MS1 high.
- R3: In modes 1 and 3, MS2 is active when `ms2_i XOR pull_up_i` is 1. An active MS2 makes the index 3 (D) on the edge that samples it. This holds from the first cycle after reset. MS1 edges seen while D is forced have no effect on the index, either then or afterwards.
- R4: In mode 1, MS1 presses step only through indices 0 to 2. From the highest valid index below 3, a press returns to 0.
- R5: When the forced D ends in mode 1, the index returns to the profile that was active before D was forced.
- R6: MS2 counts as closed when it is high with pull-down selected (`pull_up_i`=0), and when it is low with pull-up selected (`pull_up_i`=1).
- R7: In mode 2, the index equals the two-bit code {MS2, MS1}: MS1=1, MS2=0 gives B; MS1=0, MS2=1 gives C; both high give D. No press is needed; the index follows the code on every edge.
- R8: In modes 2 and 3, a code that selects a profile whose mask bit is clear gives index 0 (A).
- R9: In mode 3, when MS2 is inactive, MS1 low selects A and MS1 high selects B. The index is never 2 (C). While MS2 is active, MS1 is ignored.
- R10: If the debounce length P is not 0, a forced D ends only on the P-th millisecond tick during which MS2 has been inactive without a break. An active sample restarts the count. If P is 0, a forced D ends on the first edge at which MS2 is inactive.
- R11: MS1 edges that occur while the power-on hold is high have no effect, either then or after the hold is released.
- R12: The change pulse is high for exactly the one cycle in which the index takes a new value. It never rises when the index stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms1_i | input | 1 | Synchronized MS1 level, high = pressed or closed |
| ms2_i | input | 1 | Synchronized MS2 level, raw pin polarity |
| pull_up_i | input | 1 | 1 = pull-up resistors, so MS2 is active-low |
| mode_i | input | 2 | Pin interpretation mode, 0 to 3 |
| mem_ok_i | input | 4 | Bit i set = profile i is valid |
| deb_ms_i | input | DEB_W | Debounce length in millisecond ticks |
| pwr_hold_i | input | 1 | Power-on hold; button presses are ignored while high |
| tick_ms_i | input | 1 | One-cycle pulse once per millisecond |
| mem_sel_o | output | 2 | Active profile index, 0 = A to 3 = D |
| mem_chg_o | output | 1 | One-cycle pulse when the index changes |

## Verification
A corrupted stored profile shows nothing at the ports until the moment it is used. In mode 1 that moment is the next press, or the end of a forced D. So the bench forces D, releases it, and checks that the index comes back to the profile it held before. A debounce counter that is off by one shows as an exit from D one tick early or one tick late. The bench therefore checks the index on every tick of the window, including the ticks that come after an active sample restarted the count. A fault in the press-edge register or in the hold gating shows as an index change or a change pulse on the same edge as the offending sample. Every table row checks both outputs one edge after its inputs are applied.

// File: rtl/memsel_pkg.sv
`timescale 1ns/1ps
package memsel_pkg;
  localparam int MEM_N = 4;
  localparam int IDX_W = $clog2(MEM_N);

  typedef logic [IDX_W-1:0] mem_idx_t;
  typedef logic [MEM_N-1:0] mem_mask_t;

  localparam mem_idx_t MEM_A = '0;
  localparam mem_idx_t MEM_D = mem_idx_t'(MEM_N - 1);

  typedef enum logic [1:0] {
    SEL_PULSE       = 2'd0,
    SEL_PULSE_DJUMP = 2'd1,
    SEL_LEVEL       = 2'd2,
    SEL_LEVEL_DJUMP = 2'd3
  } sel_mode_t;

  // Next valid index above cur; A when none. skip_d removes the top index.
  function automatic mem_idx_t step_next(mem_idx_t cur, mem_mask_t ok, logic skip_d);
    mem_idx_t r;
    logic hit;
    r = MEM_A;
    hit = 1'b0;
    for (int i = 1; i < MEM_N; i++) begin
      if (!hit && (i > int'(cur)) && ok[i] && !(skip_d && (i == MEM_N - 1))) begin
        r = mem_idx_t'(i);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  // Level code to index, falling back to A when the target is not valid.
  function automatic mem_idx_t level_pick(mem_idx_t code, mem_mask_t ok);
    return ok[code] ? code : MEM_A;
  endfunction

  // Open-interval counter reaches its limit.
  function automatic logic quiet_done(int unsigned cnt_next, int unsigned limit);
    return cnt_next >= limit;
  endfunction
endpackage

// File: rtl/memsel_press.sv
`timescale 1ns/1ps
module memsel_press (
  input  logic clk,
  input  logic rst_n,
  input  logic ms1,
  input  logic hold,
  input  logic block,
  output logic press
);
  logic ms1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ms1_q <= 1'b0;
    else        ms1_q <= ms1;
  end

  logic rise;
  assign rise  = ms1 & ~ms1_q;
  assign press = rise & ~hold & ~block;

  // R11: an edge seen during the hold leaves the level remembered, so no late press
  p_hold_no_late_press_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && ms1) |=> !press || !$past(ms1));
endmodule

// File: rtl/memsel_dforce.sv
`timescale 1ns/1ps
module memsel_dforce #(
  parameter int DEB_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ms2_on,
  input  logic             tick,
  input  logic [DEB_W-1:0] period,
  output logic             force_nxt,
  output logic             force_q
);
  import memsel_pkg::*;

  logic [DEB_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             open_wait;

  assign cnt_inc   = cnt_q + DEB_W'(1);
  assign open_wait = en & ~ms2_on & force_q;

  always_comb begin
    force_nxt = force_q;
    cnt_d     = cnt_q;
    if (!en) begin
      force_nxt = 1'b0;
      cnt_d     = '0;
    end else if (ms2_on) begin
      force_nxt = 1'b1;
      cnt_d     = '0;
    end else if (open_wait) begin
      if (period == '0) begin
        force_nxt = 1'b0;
        cnt_d     = '0;
      end else if (tick) begin
        if (quiet_done(int'(cnt_inc), int'(period))) begin
          force_nxt = 1'b0;
          cnt_d     = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      force_q <= force_nxt;
      cnt_q   <= cnt_d;
    end
  end

  p_enter_d_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ms2_on) |=> force_q);

  p_leave_only_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(force_q) && $past(en)) |-> $past(!ms2_on));

  p_leave_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(force_q) && $past(en) && ($past(period) != '0)) |-> $past(tick));
endmodule

// File: rtl/memsel_home.sv
`timescale 1ns/1ps
module memsel_home
  import memsel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sel_mode_t mode,
  input  logic      ms1,
  input  logic      ms2,
  input  mem_mask_t ok,
  input  logic      press,
  output mem_idx_t  home_d,
  output mem_idx_t  home_q
);
  always_comb begin
    home_d = home_q;
    case (mode)
      SEL_PULSE:       if (press) home_d = step_next(home_q, ok, 1'b0);
      SEL_PULSE_DJUMP: if (press) home_d = step_next(home_q, ok, 1'b1);
      SEL_LEVEL:       home_d = level_pick({ms2, ms1}, ok);
      default:         home_d = level_pick({1'b0, ms1}, ok);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) home_q <= MEM_A;
    else        home_q <= home_d;
  end

  p_press_skips_d_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SEL_PULSE_DJUMP && press) |=> home_q != MEM_D);

  p_level_djump_no_c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SEL_LEVEL_DJUMP) |=> home_q[IDX_W-1] == 1'b0);
endmodule

// File: rtl/memsel_ctrl.sv
`timescale 1ns/1ps
module memsel_ctrl #(
  parameter int DEB_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms1_i,
  input  logic             ms2_i,
  input  logic             pull_up_i,
  input  logic [1:0]       mode_i,
  input  logic [3:0]       mem_ok_i,
  input  logic [DEB_W-1:0] deb_ms_i,
  input  logic             pwr_hold_i,
  input  logic             tick_ms_i,
  output logic [1:0]       mem_sel_o,
  output logic             mem_chg_o
);
  import memsel_pkg::*;

  sel_mode_t mode_e;
  logic      djump, ms2_on, press, force_nxt, force_q;
  mem_idx_t  home_d, home_q, act_d, act_q;
  logic      chg_q;

  assign mode_e = sel_mode_t'(mode_i);
  assign djump  = (mode_e == SEL_PULSE_DJUMP) || (mode_e == SEL_LEVEL_DJUMP);
  assign ms2_on = ms2_i ^ pull_up_i;

  memsel_press u_press (
    .clk   (clk),
    .rst_n (rst_n),
    .ms1   (ms1_i),
    .hold  (pwr_hold_i),
    .block (force_nxt),
    .press (press)
  );

  memsel_dforce #(.DEB_W(DEB_W)) u_dforce (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (djump),
    .ms2_on    (ms2_on),
    .tick      (tick_ms_i),
    .period    (deb_ms_i),
    .force_nxt (force_nxt),
    .force_q   (force_q)
  );

  memsel_home u_home (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode_e),
    .ms1    (ms1_i),
    .ms2    (ms2_i),
    .ok     (mem_ok_i),
    .press  (press),
    .home_d (home_d),
    .home_q (home_q)
  );

  assign act_d = force_nxt ? MEM_D : home_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= MEM_A;
      chg_q <= 1'b0;
    end else begin
      act_q <= act_d;
      chg_q <= (act_d != act_q);
    end
  end

  assign mem_sel_o = act_q;
  assign mem_chg_o = chg_q;

  p_pulse_on_change_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> chg_q);

  p_pulse_only_change_r12: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (act_q != $past(act_q)));

  p_hold_keeps_home_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == SEL_PULSE && pwr_hold_i) |=> $stable(home_q));

  p_forced_shows_d_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (djump && ms2_on) |=> mem_sel_o == 2'd3);
endmodule

// File: tb/tb_memsel_ctrl.sv
`timescale 1ns/1ps
module tb_memsel_ctrl;
  localparam int DEB_W = 12;
  localparam int NROW  = 58;

  typedef struct packed {
    logic [1:0] mode;
    logic       pu;
    logic       m1;
    logic       m2;
    logic       hold;
    logic       tick;
    logic [3:0] mask;
    logic [3:0] per;
    logic [1:0] idx;
    logic       stb;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t v(int mode, int pu, int m1, int m2, int hold, int tick,
                             int mask, int per, int idx, int stb, int req);
    vec_t r;
    r.mode = 2'(mode); r.pu = 1'(pu); r.m1 = 1'(m1); r.m2 = 1'(m2);
    r.hold = 1'(hold); r.tick = 1'(tick); r.mask = 4'(mask); r.per = 4'(per);
    r.idx = 2'(idx); r.stb = 1'(stb); r.req = 4'(req);
    return r;
  endfunction

  // fields: mode pu ms1 ms2 hold tick mask per | idx strobe | requirement
  localparam vec_t TBL [NROW] = '{
    // R2: push-button walk over all four profiles
    v(0,0,0,0,0,0,15,0, 0,0, 2), v(0,0,1,0,0,0,15,0, 1,1, 2),
    v(0,0,1,0,0,0,15,0, 1,0, 2), v(0,0,0,0,0,0,15,0, 1,0, 2),
    v(0,0,1,0,0,0,15,0, 2,1, 2), v(0,0,0,0,0,0,15,0, 2,0, 2),
    v(0,0,1,0,0,0,15,0, 3,1, 2), v(0,0,0,0,0,0,15,0, 3,0, 2),
    v(0,0,1,0,0,0,15,0, 0,1, 2), v(0,0,0,0,0,0,15,0, 0,0, 2),
    // R2: only A and C valid, B skipped
    v(0,0,1,0,0,0, 5,0, 2,1, 2), v(0,0,0,0,0,0, 5,0, 2,0, 2),
    v(0,0,1,0,0,0, 5,0, 0,1, 2), v(0,0,0,0,0,0, 5,0, 0,0, 2),
    // R2: no valid profile above A
    v(0,0,1,0,0,0, 0,0, 0,0, 2), v(0,0,0,0,0,0, 0,0, 0,0, 2),
    // R11: edge under the power-on hold is dropped for good
    v(0,0,1,0,1,0,15,0, 0,0,11), v(0,0,1,0,0,0,15,0, 0,0,11),
    v(0,0,0,0,0,0,15,0, 0,0,11),
    // R4: cycling with D reserved for the override
    v(1,0,1,0,0,0,15,0, 1,1, 4), v(1,0,0,0,0,0,15,0, 1,0, 4),
    v(1,0,1,0,0,0,15,0, 2,1, 4), v(1,0,0,0,0,0,15,0, 2,0, 4),
    v(1,0,1,0,0,0,15,0, 0,1, 4), v(1,0,0,0,0,0,15,0, 0,0, 4),
    v(1,0,1,0,0,0,15,0, 1,1, 4), v(1,0,0,0,0,0,15,0, 1,0, 4),
    // R3: override, press ignored; R5: restore B
    v(1,0,0,1,0,0,15,0, 3,1, 3), v(1,0,1,1,0,0,15,0, 3,0, 3),
    v(1,0,0,1,0,0,15,0, 3,0, 3), v(1,0,0,0,0,0,15,0, 1,1, 5),
    // R6: pull-up makes MS2 active-low
    v(1,1,0,1,0,0,15,0, 1,0, 6), v(1,1,0,0,0,0,15,0, 3,1, 6),
    v(1,1,0,1,0,0,15,0, 1,1, 5),
    // R10: three-tick release window with a restart
    v(1,0,0,1,0,0,15,3, 3,1, 3), v(1,0,0,0,0,1,15,3, 3,0,10),
    v(1,0,0,0,0,0,15,3, 3,0,10), v(1,0,0,0,0,1,15,3, 3,0,10),
    v(1,0,0,1,0,1,15,3, 3,0,10), v(1,0,0,0,0,1,15,3, 3,0,10),
    v(1,0,0,0,0,1,15,3, 3,0,10), v(1,0,0,0,0,1,15,3, 1,1,10),
    v(1,0,0,0,0,0,15,3, 1,0,12),
    // R7: two-switch code; R8: invalid C falls back to A
    v(2,0,0,0,0,0,15,0, 0,1, 7), v(2,0,1,0,0,0,15,0, 1,1, 7),
    v(2,0,0,1,0,0,15,0, 2,1, 7), v(2,0,1,1,0,0,15,0, 3,1, 7),
    v(2,0,1,1,0,0,15,0, 3,0,12), v(2,0,0,1,0,0,11,0, 0,1, 8),
    v(2,0,1,1,0,0,11,0, 3,1, 7),
    // R9: static override mode; R8 with B invalid; R6 pull-up
    v(3,0,1,0,0,0,15,0, 1,1, 9), v(3,0,0,0,0,0,15,0, 0,1, 9),
    v(3,0,0,1,0,0,15,0, 3,1, 9), v(3,0,1,1,0,0,15,0, 3,0, 9),
    v(3,0,1,0,0,0,15,0, 1,1, 9), v(3,0,1,0,0,0,13,0, 0,1, 8),
    v(3,1,0,0,0,0,15,0, 3,1, 6), v(3,1,0,1,0,0,15,0, 0,1, 6)
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ms1_i, ms2_i, pull_up_i, pwr_hold_i, tick_ms_i;
  logic [1:0]       mode_i;
  logic [3:0]       mem_ok_i;
  logic [DEB_W-1:0] deb_ms_i;
  logic [1:0]       mem_sel_o;
  logic             mem_chg_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  memsel_ctrl #(.DEB_W(DEB_W)) dut (
    .clk(clk), .rst_n(rst_n), .ms1_i(ms1_i), .ms2_i(ms2_i), .pull_up_i(pull_up_i),
    .mode_i(mode_i), .mem_ok_i(mem_ok_i), .deb_ms_i(deb_ms_i),
    .pwr_hold_i(pwr_hold_i), .tick_ms_i(tick_ms_i),
    .mem_sel_o(mem_sel_o), .mem_chg_o(mem_chg_o)
  );

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic apply(vec_t r);
    mode_i = r.mode; pull_up_i = r.pu; ms1_i = r.m1; ms2_i = r.m2;
    pwr_hold_i = r.hold; tick_ms_i = r.tick; mem_ok_i = r.mask;
    deb_ms_i = DEB_W'(r.per);
  endtask

  initial begin
    rst_n = 1'b0;
    apply(v(0,0,0,0,0,0,15,0,0,0,1));
    repeat (3) @(posedge clk);
    #1;
    // R1: during reset
    check("R1 idx in reset", int'(mem_sel_o), 0);
    check("R1 strobe in reset", int'(mem_chg_o), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 idx after reset", int'(mem_sel_o), 0);
    check("R1 strobe after reset", int'(mem_chg_o), 0);

    for (int k = 0; k < NROW; k++) begin
      apply(TBL[k]);
      @(posedge clk); #1;
      check($sformatf("R%0d row %0d idx", TBL[k].req, k), int'(mem_sel_o), int'(TBL[k].idx));
      check($sformatf("R%0d row %0d strobe", TBL[k].req, k), int'(mem_chg_o), int'(TBL[k].stb));
    end

    // R1: reset in the middle of operation returns to A
    apply(v(0,0,0,0,0,0,15,0,0,0,1));
    rst_n = 1'b0;
    #1;
    check("R1 idx mid-run reset", int'(mem_sel_o), 0);
    check("R1 strobe mid-run reset", int'(mem_chg_o), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R3: override present at the first edge after reset
    apply(v(1,0,0,1,0,0,15,0,3,1,3));
    @(posedge clk); #1;
    check("R3 startup override idx", int'(mem_sel_o), 3);
    check("R12 startup override strobe", int'(mem_chg_o), 1);
    @(posedge clk); #1;
    check("R12 strobe single cycle", int'(mem_chg_o), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule